// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Status Flags and Branch Condition Test

This block is the arithmetic core of a small 8-bit processor datapath. Each cycle in which `opValid` is high it combines the accumulator value on `accIn` with a second operand on `operandIn` according to `opCode`. It presents the result on `resultOut` in the same cycle, together with a write strobe that tells the register side whether the result should be stored. The status flags are registered. They update on the clock edge that ends the operation and stay unchanged otherwise.

The registered flags are sign, zero, parity, auxiliary (nibble) carry and carry. They are packed into a byte-wide status word for saving and restoring. The add-with-carry operation uses the stored carry as its carry input. A condition tester reads the stored flags and a 3-bit condition code and gives a taken or not-taken decision for conditional jumps, calls and returns.

Top module: `alu_flags_top`

## Requirements
- R1: After reset all five flags are 0, so `statusWord` reads 8'h02.
- R2: The operation codes are: 0 add, 1 add with stored carry, 2 subtract, 3 compare, 4 AND, 5 OR, 6 XOR, 7 complement accumulator, 8 increment accumulator. For add, add with carry, subtract, AND, OR, XOR, complement and increment, `resultOut` equals the 8-bit operation result and `resultWe` is high while `opValid` is high.
- R3: Carry becomes 1 on a carry out of bit 7 for add and add with carry. For subtract and compare it becomes 1 when a borrow occurs (accIn < operandIn unsigned). Otherwise it becomes 0.
- R4: For every flag-updating operation, sign becomes bit 7 of the result, zero becomes 1 exactly when the result is 8'h00, and parity becomes 1 exactly when the result has an even number of ones.
- R5: Auxiliary carry becomes the carry out of bit 3. For add, add with carry and increment this is the low-nibble sum. For subtract and compare it is the nibble carry of accIn + ~operandIn + 1, so it is 1 when accIn[3:0] >= operandIn[3:0].
- R6: Add with carry computes accIn + operandIn + stored carry.
- R7: Compare (code 3) updates the flags exactly as subtract would and holds `resultWe` low.
- R8: Increment (code 8) returns accIn + 1 and updates sign, zero, parity and auxiliary carry, but leaves carry unchanged.
- R9: AND, OR and XOR clear carry and auxiliary carry. Complement (code 7) leaves all flags unchanged.
- R10: Codes 9 to 15 and any cycle with `opValid` low hold `resultWe` low and leave every flag unchanged.
- R11: The status word places sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5 and 3 read 0 and bit 1 reads 1.
- R12: `condTaken` is computed from the stored flags. Codes 0..7 select: zero clear, zero set, carry clear, carry set, parity clear (odd), parity set (even), sign clear (plus), sign set (minus).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is issued this cycle |
| opCode | input | 4 | Operation select |
| accIn | input | 8 | Accumulator operand |
| operandIn | input | 8 | Second operand |
| condCode | input | 3 | Branch condition select |
| resultOut | output | 8 | Operation result (combinational) |
| resultWe | output | 1 | Result should be written back |
| statusWord | output | 8 | Packed registered flags |
| condTaken | output | 1 | Selected condition holds |

## Verification
The hardest situations to reach from the ports depend on flag history rather than on the current inputs. Examples are an add-with-carry that must pick up a carry left by an earlier operation, and an increment that wraps to zero while an older carry must survive it. The stimulus therefore runs chained sequences: an add that overflows, then an add-with-carry; a borrow-producing subtract, then an increment of 8'hFF; a logic operation after a carry. Each step is checked against a model whose flags carry over between operations. All eight branch conditions are then swept against those flags.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_CMP = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_NOT = 4'd7,
    OP_INC = 4'd8
  } aluOp_e;

  typedef enum logic [2:0] {
    UNIT_ARITH = 3'd0,
    UNIT_AND   = 3'd1,
    UNIT_OR    = 3'd2,
    UNIT_XOR   = 3'd3,
    UNIT_NOT   = 3'd4
  } unitSel_e;

  // strobes from control to datapath
  typedef struct packed {
    unitSel_e unitSel;
    logic     invB;
    logic     cinFromFlag;
    logic     cinOne;
    logic     bIsOne;
    logic     wrRes;
    logic     updCy;
    logic     updRest;
  } aluStrobes_t;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flagSet_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_flags_pkg::*;
(
  input  logic        opValid,
  input  logic [3:0]  opCode,
  output aluStrobes_t strobes
);

  aluStrobes_t dec;

  always_comb begin
    dec = '0;
    dec.unitSel = UNIT_ARITH;
    case (opCode)
      OP_ADD: begin
        dec.wrRes = 1'b1; dec.updCy = 1'b1; dec.updRest = 1'b1;
      end
      OP_ADC: begin
        dec.cinFromFlag = 1'b1;
        dec.wrRes = 1'b1; dec.updCy = 1'b1; dec.updRest = 1'b1;
      end
      OP_SUB: begin
        dec.invB = 1'b1; dec.cinOne = 1'b1;
        dec.wrRes = 1'b1; dec.updCy = 1'b1; dec.updRest = 1'b1;
      end
      OP_CMP: begin
        dec.invB = 1'b1; dec.cinOne = 1'b1;
        dec.updCy = 1'b1; dec.updRest = 1'b1;
      end
      OP_AND: begin
        dec.unitSel = UNIT_AND;
        dec.wrRes = 1'b1; dec.updCy = 1'b1; dec.updRest = 1'b1;
      end
      OP_OR: begin
        dec.unitSel = UNIT_OR;
        dec.wrRes = 1'b1; dec.updCy = 1'b1; dec.updRest = 1'b1;
      end
      OP_XOR: begin
        dec.unitSel = UNIT_XOR;
        dec.wrRes = 1'b1; dec.updCy = 1'b1; dec.updRest = 1'b1;
      end
      OP_NOT: begin
        dec.unitSel = UNIT_NOT;
        dec.wrRes = 1'b1;
      end
      OP_INC: begin
        dec.bIsOne = 1'b1;
        dec.wrRes = 1'b1; dec.updRest = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    strobes = dec;
    strobes.wrRes   = dec.wrRes   & opValid;
    strobes.updCy   = dec.updCy   & opValid;
    strobes.updRest = dec.updRest & opValid;
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobes_t       strobes,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  output logic [DATA_W-1:0] resultOut,
  output flagSet_t          flagsQ
);

  localparam int NIB_W = 4;

  logic [DATA_W-1:0] bSel, bEff, logicRes;
  logic              cin;
  logic [DATA_W:0]   fullSum;
  logic [NIB_W:0]    lowSum;
  logic              arithCy, nextCy, nextAc;
  logic              isArith;

  assign bSel    = strobes.bIsOne ? DATA_W'(1) : operandIn;
  assign bEff    = strobes.invB ? ~bSel : bSel;
  assign cin     = strobes.cinOne | (strobes.cinFromFlag & flagsQ.cy);
  assign fullSum = {1'b0, accIn} + {1'b0, bEff} + {{DATA_W{1'b0}}, cin};
  assign lowSum  = {1'b0, accIn[NIB_W-1:0]} + {1'b0, bEff[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, cin};
  // subtraction carry is reported as borrow
  assign arithCy = strobes.invB ? ~fullSum[DATA_W] : fullSum[DATA_W];
  assign isArith = (strobes.unitSel == UNIT_ARITH);

  always_comb begin
    case (strobes.unitSel)
      UNIT_AND: logicRes = accIn & operandIn;
      UNIT_OR:  logicRes = accIn | operandIn;
      UNIT_XOR: logicRes = accIn ^ operandIn;
      UNIT_NOT: logicRes = ~accIn;
      default:  logicRes = '0;
    endcase
  end

  assign resultOut = isArith ? fullSum[DATA_W-1:0] : logicRes;
  assign nextCy    = isArith & arithCy;
  assign nextAc    = isArith & lowSum[NIB_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else begin
      if (strobes.updCy) flagsQ.cy <= nextCy;
      if (strobes.updRest) begin
        flagsQ.s  <= resultOut[DATA_W-1];
        flagsQ.z  <= (resultOut == '0);
        flagsQ.p  <= ~^resultOut;
        flagsQ.ac <= nextAc;
      end
    end
  end

  // R8
  cy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.updCy |=> $stable(flagsQ.cy));

  // R3
  borrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.updCy && strobes.invB) |=> (flagsQ.cy == ($past(accIn) < $past(operandIn))));

  // R9
  logic_cy_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.updCy && !isArith) |=> (!flagsQ.cy && !flagsQ.ac));

  // R4
  parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updRest |=> (flagsQ.p == ~^$past(resultOut)));

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_flags_pkg::*;
(
  input  flagSet_t   flags,
  input  logic [2:0] condCode,
  output logic       condTaken
);

  logic selFlag;

  // codes pair up: even selects "flag clear", odd selects "flag set"
  always_comb begin
    case (condCode[2:1])
      2'd0:    selFlag = flags.z;
      2'd1:    selFlag = flags.cy;
      2'd2:    selFlag = flags.p;
      default: selFlag = flags.s;
    endcase
  end

  assign condTaken = condCode[0] ? selFlag : ~selFlag;

endmodule

// File: rtl/alu_flags_top.sv
module alu_flags_top
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [2:0]        condCode,
  output logic [DATA_W-1:0] resultOut,
  output logic              resultWe,
  output logic [7:0]        statusWord,
  output logic              condTaken
);

  aluStrobes_t strobes;
  flagSet_t    flagsQ;

  alu_ctrl i_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobes (strobes)
  );

  alu_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .accIn     (accIn),
    .operandIn (operandIn),
    .resultOut (resultOut),
    .flagsQ    (flagsQ)
  );

  alu_cond_eval i_cond (
    .flags     (flagsQ),
    .condCode  (condCode),
    .condTaken (condTaken)
  );

  assign resultWe   = strobes.wrRes;
  assign statusWord = {flagsQ.s, flagsQ.z, 1'b0, flagsQ.ac,
                       1'b0, flagsQ.p, 1'b1, flagsQ.cy};

  // R7
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd3) |-> !resultWe);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(statusWord));

  // R12
  carry_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == 3'd3) |-> (condTaken == statusWord[0]));

endmodule

// File: tb/test_alu_flags_top.sv
module test_alu_flags_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       opValid;
  logic [3:0] opCode;
  logic [7:0] accIn, operandIn;
  logic [2:0] condCode;
  logic [7:0] resultOut;
  logic       resultWe;
  logic [7:0] statusWord;
  logic       condTaken;

  int total = 0;
  int bad = 0;

  // model flags
  logic mS = 0, mZ = 0, mAc = 0, mP = 0, mCy = 0;

  always #5 clk = ~clk;

  alu_flags_top i_alu_flags_top (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .accIn(accIn), .operandIn(operandIn), .condCode(condCode),
    .resultOut(resultOut), .resultWe(resultWe), .statusWord(statusWord),
    .condTaken(condTaken)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] packWord();
    return {mS, mZ, 1'b0, mAc, 1'b0, mP, 1'b1, mCy};
  endfunction

  // issue one op, check result/write strobe and flags after the edge
  task automatic runOp(input string req, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic valid);
    int sum;
    logic [7:0] r;
    logic we, doCy, doRest, nCy, nAc;
    r = 8'h00; we = 0; doCy = 0; doRest = 0; nCy = 0; nAc = 0;
    if (valid) begin
      case (op)
        4'd0, 4'd1: begin
          sum = int'(a) + int'(b) + ((op == 4'd1 && mCy) ? 1 : 0);
          r = sum[7:0]; nCy = (sum > 255);
          nAc = ((int'(a[3:0]) + int'(b[3:0]) + ((op == 4'd1 && mCy) ? 1 : 0)) > 15);
          we = 1; doCy = 1; doRest = 1;
        end
        4'd2, 4'd3: begin
          r = a - b; nCy = (a < b); nAc = (a[3:0] >= b[3:0]);
          we = (op == 4'd2); doCy = 1; doRest = 1;
        end
        4'd4: begin r = a & b; we = 1; doCy = 1; doRest = 1; end
        4'd5: begin r = a | b; we = 1; doCy = 1; doRest = 1; end
        4'd6: begin r = a ^ b; we = 1; doCy = 1; doRest = 1; end
        4'd7: begin r = ~a; we = 1; end
        4'd8: begin r = a + 8'd1; nAc = (a[3:0] == 4'hF); we = 1; doRest = 1; end
        default: ;
      endcase
    end
    @(negedge clk);
    opValid = valid; opCode = op; accIn = a; operandIn = b;
    #2;
    if (we) check(req, "resultOut", resultOut, r);
    check(req, "resultWe", resultWe, we);
    @(posedge clk);
    #1;
    opValid = 1'b0;
    if (doCy) mCy = nCy;
    if (doRest) begin
      mS = r[7]; mZ = (r == 8'h00); mP = ~^r; mAc = nAc;
    end
    check(req, "statusWord", statusWord, packWord());
  endtask

  task automatic sweepConds(input string req);
    logic e;
    for (int c = 0; c < 8; c++) begin
      condCode = 3'(c);
      #1;
      case (c)
        0: e = !mZ;  1: e = mZ;
        2: e = !mCy; 3: e = mCy;
        4: e = !mP;  5: e = mP;
        6: e = !mS;  default: e = mS;
      endcase
      check(req, $sformatf("condTaken code %0d", c), condTaken, e);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "statusWord after reset", statusWord, 8'h02);
    check("R11", "fixed bits", statusWord & 8'h2A, 8'h02);
    sweepConds("R12");
  endtask

  task automatic testAdds();
    runOp("R3", 4'd0, 8'h98, 8'h9A, 1);   // 0x32 with carry
    runOp("R6", 4'd1, 8'h10, 8'h05, 1);   // picks up carry -> 0x16
    runOp("R5", 4'd0, 8'h0F, 8'h01, 1);   // nibble carry
    runOp("R4", 4'd0, 8'hFF, 8'h01, 1);   // zero, carry
    runOp("R6", 4'd1, 8'hFF, 8'hFF, 1);   // FF+FF+1 = FF carry
    sweepConds("R12");
  endtask

  task automatic testSubs();
    runOp("R3", 4'd2, 8'h49, 8'h32, 1);   // 0x17 no borrow
    runOp("R3", 4'd2, 8'h12, 8'h34, 1);   // borrow
    runOp("R5", 4'd2, 8'h20, 8'h01, 1);   // nibble borrow
    runOp("R7", 4'd3, 8'h55, 8'h55, 1);   // equal, no write
    sweepConds("R12");
    runOp("R7", 4'd3, 8'h01, 8'h80, 1);   // borrow, no write
    sweepConds("R12");
  endtask

  task automatic testLogic();
    runOp("R3", 4'd0, 8'hF0, 8'h20, 1);   // set carry first
    runOp("R9", 4'd4, 8'hF3, 8'h3C, 1);
    runOp("R9", 4'd5, 8'h80, 8'h01, 1);
    runOp("R9", 4'd6, 8'hAA, 8'hAA, 1);
    runOp("R2", 4'd0, 8'h7F, 8'h01, 1);   // sign set, nibble carry
    runOp("R9", 4'd7, 8'h0F, 8'h00, 1);   // complement keeps flags
    sweepConds("R12");
  endtask

  task automatic testIncrement();
    runOp("R3", 4'd2, 8'h00, 8'h01, 1);   // carry=1
    runOp("R8", 4'd8, 8'hFF, 8'h00, 1);   // wraps, carry kept 1
    runOp("R4", 4'd4, 8'h00, 8'h00, 1);   // carry=0
    runOp("R8", 4'd8, 8'hFF, 8'h00, 1);   // wraps, carry kept 0
    runOp("R8", 4'd8, 8'h3E, 8'h00, 1);
    sweepConds("R12");
  endtask

  task automatic testNoEffect();
    runOp("R4", 4'd2, 8'h05, 8'h05, 1);   // distinctive flag state
    runOp("R10", 4'd9,  8'h12, 8'h34, 1);
    runOp("R10", 4'd15, 8'hFF, 8'h01, 1);
    runOp("R10", 4'd0,  8'hFF, 8'h01, 0); // opValid low
    sweepConds("R12");
  endtask

  initial begin
    rstN = 1'b0; opValid = 1'b0; opCode = 4'd0; accIn = 8'h00;
    operandIn = 8'h00; condCode = 3'd0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testAdds();
    testSubs();
    testLogic();
    testIncrement();
    testNoEffect();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule